// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block sits in the read data path of a flash-style memory and decides what a host read returns while an embedded program or erase operation is in flight. While the operation engine reports busy, the read byte is replaced by a status byte. One bit of that byte is a polling bit that carries the inverse of the target data while programming and 0 while erasing. A second bit is a toggle bit that inverts after every completed read. Once busy drops, reads return plain array data again. A program that has finished therefore reads back its written byte, and an erased location reads back all ones.

The operation engine supplies the busy flag, the kind of operation, an erase-suspend flag and the byte being programmed. The address decoder supplies a flag that says whether the current read address lies in the region the operation touches. The host side supplies a chip-select level and an output-enable level. A read is complete when the two have both been high and then either of them goes low. The block drives the read byte and a flag that tells the pad logic to enable the output drivers. The reset is asynchronous and active low, and the block releases it synchronously.

Top module: `status_reporter`

## Requirements
- R1: After reset, with `busy_i` low, a read with `sel_i` and `oe_i` both high returns `array_i` on `rd_data_o`.
- R2: `rd_drive_o` is 1 exactly when `sel_i` and `oe_i` are both 1. While it is 0, `rd_data_o` reads all zeros.
- R3: While busy on a program (`op_kind_i` = 0) with `addr_hit_i` = 1, bit 7 of a read returns the inverse of bit 7 of `target_i`.
- R4: While busy on an erase (`op_kind_i` = 1), bit 7 of every status read is 0.
- R5: While busy and not held by suspend, bit 6 of the status byte inverts after every completed read. A read is complete when `sel_i & oe_i` is seen high at one clock edge and low at the next.
- R6: In a status byte, bits 5 down to 0 are 0.
- R7: When `busy_i` is low, reads return `array_i`. After a program has finished, this means the written byte is read back.
- R8: During an erase with `suspend_i` = 1, reads with `addr_hit_i` = 0 return `array_i` and do not advance the toggle bit. `suspend_i` has no effect during a program.
- R9: During a suspended erase, reads with `addr_hit_i` = 1 return a status byte in which bit 7 is 0 and bit 6 holds its value from read to read.
- R10: While busy on a program with `addr_hit_i` = 0, bit 7 of the status byte is 0.
- R11: The toggle bit returns to 0 while `busy_i` is low, so the first status read of each new operation shows bit 6 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| busy_i | input | 1 | Operation engine is running an embedded operation |
| op_kind_i | input | 1 | Operation kind: 0 program, 1 erase |
| suspend_i | input | 1 | Erase is suspended (ignored for program) |
| target_i | input | DATA_W | Byte being programmed |
| addr_hit_i | input | 1 | Read address lies in the region the operation touches |
| sel_i | input | 1 | Chip select level, active high |
| oe_i | input | 1 | Output enable level, active high |
| array_i | input | DATA_W | Array data for the current read address |
| rd_data_o | output | DATA_W | Byte returned to the host |
| rd_drive_o | output | 1 | Output drivers enabled |

## Verification
The assertions assume three things about the inputs. `sel_i` and `oe_i` are low while reset is asserted and during its release. The operation kind, suspend flag and target byte change only while no read is open. Every input is stable around the rising clock edge. The stimulus meets these assumptions as follows: it keeps both read controls low through reset, and it changes the operation inputs only between reads. It drives every input on the falling clock edge. Each read holds the controls high for one full clock, so every completed read is seen exactly once by the edge detector.

// File: rtl/status_reporter_pkg.sv
package status_reporter_pkg;

  typedef enum logic {
    OPK_PROGRAM = 1'b0,
    OPK_ERASE   = 1'b1
  } op_kind_e;

endpackage

// File: rtl/sr_reset_sync.sv
module sr_reset_sync (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/sr_read_edge.sv
module sr_read_edge (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic rd_level_i,
  output logic rd_done_o
);

  logic rd_q;
  logic rd_d;

  always_comb begin
    rd_d = rd_level_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rd_q <= 1'b0;
    end else begin
      rd_q <= rd_d;
    end
  end

  // a read closes when the level was high last edge and is low now
  assign rd_done_o = rd_q & ~rd_level_i;

endmodule

// File: rtl/sr_toggle_unit.sv
module sr_toggle_unit (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic clear_i,
  input  logic flip_i,
  output logic tog_o
);

  logic tog_q;
  logic tog_d;
  logic tog_en;

  always_comb begin
    tog_en = clear_i | flip_i;
    if (clear_i) begin
      tog_d = 1'b0;
    end else begin
      tog_d = ~tog_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      tog_q <= 1'b0;
    end else if (tog_en) begin
      tog_q <= tog_d;
    end
  end

  assign tog_o = tog_q;

endmodule

// File: rtl/sr_status_byte.sv
module sr_status_byte #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned POLL_BIT   = 7,
  parameter int unsigned TOGGLE_BIT = 6
) (
  input  logic              poll_i,
  input  logic              tog_i,
  output logic [DATA_W-1:0] status_o
);

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b == POLL_BIT) begin : g_poll
      assign status_o[b] = poll_i;
    end else if (b == TOGGLE_BIT) begin : g_tog
      assign status_o[b] = tog_i;
    end else begin : g_zero
      assign status_o[b] = 1'b0;
    end
  end

endmodule

// File: rtl/status_reporter.sv
module status_reporter
  import status_reporter_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned POLL_BIT   = 7,
  parameter int unsigned TOGGLE_BIT = 6
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              busy_i,
  input  logic              op_kind_i,
  input  logic              suspend_i,
  input  logic [DATA_W-1:0] target_i,
  input  logic              addr_hit_i,
  input  logic              sel_i,
  input  logic              oe_i,
  input  logic [DATA_W-1:0] array_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_drive_o
);

  logic              rst_n_q;
  logic              rd_level;
  logic              rd_done;
  logic              tog_w;
  op_kind_e          kind;
  logic              held;
  logic              running;
  logic              show_status;
  logic              poll_bit;
  logic [DATA_W-1:0] status_byte;
  logic [DATA_W-1:0] data_sel;
  logic              unused_tgt;

  sr_reset_sync u_rst (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_n_q)
  );

  assign rd_level = sel_i & oe_i;

  sr_read_edge u_edge (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_q),
    .rd_level_i (rd_level),
    .rd_done_o  (rd_done)
  );

  always_comb begin
    kind        = op_kind_e'(op_kind_i);
    held        = (kind == OPK_ERASE) & suspend_i;
    running     = busy_i & ~held;
    show_status = busy_i & ~(held & ~addr_hit_i);
    if (kind == OPK_PROGRAM && addr_hit_i) begin
      poll_bit = ~target_i[POLL_BIT];
    end else begin
      poll_bit = 1'b0;
    end
  end

  sr_toggle_unit u_tog (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_q),
    .clear_i (~busy_i),
    .flip_i  (running & rd_done),
    .tog_o   (tog_w)
  );

  sr_status_byte #(
    .DATA_W     (DATA_W),
    .POLL_BIT   (POLL_BIT),
    .TOGGLE_BIT (TOGGLE_BIT)
  ) u_stat (
    .poll_i   (poll_bit),
    .tog_i    (tog_w),
    .status_o (status_byte)
  );

  always_comb begin
    data_sel   = show_status ? status_byte : array_i;
    rd_drive_o = rd_level;
    rd_data_o  = rd_level ? data_sel : '0;
  end

  assign unused_tgt = ^target_i;

endmodule

// File: rtl/status_reporter_chk.sv
module status_reporter_chk #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned POLL_BIT   = 7,
  parameter int unsigned TOGGLE_BIT = 6
) (
  input logic              clk_i,
  input logic              rst_ok,
  input logic              busy_i,
  input logic              op_kind_i,
  input logic              suspend_i,
  input logic [DATA_W-1:0] target_i,
  input logic              addr_hit_i,
  input logic              sel_i,
  input logic              oe_i,
  input logic [DATA_W-1:0] array_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rd_drive_o,
  input logic              tog
);

  localparam logic [DATA_W-1:0] OTHER_MASK =
    ~((DATA_W'(1) << POLL_BIT) | (DATA_W'(1) << TOGGLE_BIT));

  logic rd_lvl;
  logic susp_erase;
  assign rd_lvl     = sel_i & oe_i;
  assign susp_erase = op_kind_i & suspend_i;

  assert_hiz_R2: assert property (@(posedge clk_i) disable iff (!rst_ok)
    !rd_lvl |-> (!rd_drive_o && rd_data_o == '0));

  assert_poll_program_R3: assert property (@(posedge clk_i) disable iff (!rst_ok)
    (busy_i && !op_kind_i && addr_hit_i && rd_drive_o)
      |-> rd_data_o[POLL_BIT] != target_i[POLL_BIT]);

  assert_poll_erase_R4: assert property (@(posedge clk_i) disable iff (!rst_ok)
    (busy_i && op_kind_i && addr_hit_i && rd_drive_o) |-> !rd_data_o[POLL_BIT]);

  assert_toggle_flip_R5: assert property (@(posedge clk_i) disable iff (!rst_ok)
    (busy_i && !susp_erase && $past(rd_lvl) && !rd_lvl) |=> tog != $past(tog));

  assert_status_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ok)
    (busy_i && !susp_erase && rd_drive_o) |-> $countones(rd_data_o & OTHER_MASK) == 0);

  assert_idle_array_R7: assert property (@(posedge clk_i) disable iff (!rst_ok)
    (!busy_i && rd_drive_o) |-> rd_data_o == array_i);

  assert_suspend_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ok)
    (busy_i && susp_erase) |=> $stable(tog));

  assert_idle_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ok)
    !busy_i |=> !tog);

endmodule

bind status_reporter status_reporter_chk #(
  .DATA_W     (DATA_W),
  .POLL_BIT   (POLL_BIT),
  .TOGGLE_BIT (TOGGLE_BIT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ok     (rst_n_q),
  .busy_i     (busy_i),
  .op_kind_i  (op_kind_i),
  .suspend_i  (suspend_i),
  .target_i   (target_i),
  .addr_hit_i (addr_hit_i),
  .sel_i      (sel_i),
  .oe_i       (oe_i),
  .array_i    (array_i),
  .rd_data_o  (rd_data_o),
  .rd_drive_o (rd_drive_o),
  .tog        (tog_w)
);

// File: tb/status_reporter_bench.sv
module status_reporter_bench;

  localparam int CLK_P = 10;

  logic       clk;
  logic       rst_n;
  logic       busy;
  logic       op_kind;
  logic       suspend;
  logic [7:0] target;
  logic       addr_hit;
  logic       sel;
  logic       oe;
  logic [7:0] array_d;
  logic [7:0] rd_data;
  logic       rd_drive;

  int  checks;
  int  errors;
  logic exp_tog;

  status_reporter u_status_reporter (
    .clk_i      (clk),
    .rst_n_i    (rst_n),
    .busy_i     (busy),
    .op_kind_i  (op_kind),
    .suspend_i  (suspend),
    .target_i   (target),
    .addr_hit_i (addr_hit),
    .sel_i      (sel),
    .oe_i       (oe),
    .array_i    (array_d),
    .rd_data_o  (rd_data),
    .rd_drive_o (rd_drive)
  );

  initial clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_read(output logic [7:0] d, output logic drv);
    @(negedge clk);
    sel = 1'b1;
    oe  = 1'b1;
    @(negedge clk);
    d   = rd_data;
    drv = rd_drive;
    sel = 1'b0;
    oe  = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_op(input logic b, input logic k, input logic s, input logic h,
                        input logic [7:0] t, input logic [7:0] a);
    @(negedge clk);
    busy = b; op_kind = k; suspend = s; addr_hit = h; target = t; array_d = a;
  endtask

  task automatic go_idle(input logic [7:0] a);
    set_op(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, a);
    @(negedge clk);
    @(negedge clk);
    exp_tog = 1'b0;
  endtask

  // status read: bit 7 poll, bit 6 toggle, rest 0; run says whether the toggle advances
  task automatic read_status(input string req, input logic poll, input logic run);
    logic [7:0] d;
    logic       drv;
    do_read(d, drv);
    check8(req, d, {poll, exp_tog, 6'b0});
    if (run) exp_tog = ~exp_tog;
  endtask

  task automatic read_array(input string req, input logic [7:0] exp);
    logic [7:0] d;
    logic       drv;
    do_read(d, drv);
    check8(req, d, exp);
    check8({req, " drive"}, {7'b0, drv}, 8'h01);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check8("R2 idle drive", {7'b0, rd_drive}, 8'h00);
    check8("R2 idle data", rd_data, 8'h00);
    sel = 1'b1;
    @(negedge clk);
    check8("R2 sel only drive", {7'b0, rd_drive}, 8'h00);
    check8("R2 sel only data", rd_data, 8'h00);
    sel = 1'b0;
    set_op(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h5A);
    read_array("R1 reset read", 8'h5A);
  endtask

  task automatic t_program;
    set_op(1'b1, 1'b0, 1'b0, 1'b1, 8'hA5, 8'hFF);
    read_status("R11 R3 first", 1'b0, 1'b1);
    read_status("R5 R6 second", 1'b0, 1'b1);
    read_status("R5 third", 1'b0, 1'b1);
    go_idle(8'hA5);
    read_array("R7 program done", 8'hA5);
    set_op(1'b1, 1'b0, 1'b0, 1'b1, 8'h12, 8'hFF);
    read_status("R11 R3 poll one", 1'b1, 1'b1);
    read_status("R5 R3 poll one", 1'b1, 1'b1);
    go_idle(8'h12);
    read_array("R7 second done", 8'h12);
  endtask

  task automatic t_prog_miss;
    set_op(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h33);
    read_status("R10 miss", 1'b0, 1'b1);
    read_status("R10 miss toggle", 1'b0, 1'b1);
    go_idle(8'h33);
  endtask

  task automatic t_erase;
    set_op(1'b1, 1'b1, 1'b0, 1'b1, 8'hFF, 8'h00);
    read_status("R4 erase", 1'b0, 1'b1);
    read_status("R4 R5 erase", 1'b0, 1'b1);
    read_status("R4 R5 erase", 1'b0, 1'b1);
    set_op(1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, 8'h9C);
    read_status("R4 erase other addr", 1'b0, 1'b1);
    go_idle(8'hFF);
    read_array("R7 erase done", 8'hFF);
  endtask

  task automatic t_suspend;
    set_op(1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00);
    read_status("R4 before suspend", 1'b0, 1'b1);
    set_op(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h77);
    read_array("R8 suspended other", 8'h77);
    read_array("R8 suspended other again", 8'h77);
    set_op(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00);
    read_status("R9 suspended hit", 1'b0, 1'b0);
    read_status("R9 suspended hold", 1'b0, 1'b0);
    set_op(1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00);
    read_status("R5 resumed", 1'b0, 1'b1);
    read_status("R5 resumed flip", 1'b0, 1'b1);
    go_idle(8'hFF);
    read_array("R7 after resume", 8'hFF);
  endtask

  task automatic t_prog_suspend_ignored;
    set_op(1'b1, 1'b0, 1'b1, 1'b1, 8'h80, 8'hFF);
    read_status("R8 program ignores suspend", 1'b0, 1'b1);
    read_status("R8 program ignores suspend toggle", 1'b0, 1'b1);
    go_idle(8'h80);
    read_array("R7 program after suspend flag", 8'h80);
  endtask

  initial begin
    checks = 0; errors = 0; exp_tog = 1'b0;
    rst_n = 1'b0; busy = 1'b0; op_kind = 1'b0; suspend = 1'b0;
    target = 8'h00; addr_hit = 1'b0; sel = 1'b0; oe = 1'b0; array_d = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_program;
    t_prog_miss;
    t_erase;
    t_suspend;
    t_prog_suspend_ignored;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog all requirements actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule